// File: doc/BRIEF.md
# Triplex LCD Multiplex Sequencer

This block sequences the drive of a three-backplane multiplexed liquid crystal panel. It has twelve segment lines, organised as four digits of three lines each, and three backplanes, A, B and C. Each line carries a 2-bit level code: 0 means ground, 1 means one third of supply, 2 means two thirds and 3 means full supply. An analog stage outside the block turns these codes into voltages. The sequencer advances on a slow oscillator tick. A frame has six polarity phases: A positive, A negative, B positive, B negative, C positive and C negative. Each phase lasts `TICKS_PER_PHASE` ticks, so a default frame is 192 ticks. During each phase the block maps every latched display bit onto its segment line for the backplane that is currently selected.

A control write latches a 2-bit role code and a hold flag. The role code decides which tick drives the sequencer. It also decides whether the A backplane pin works as an oscillator input and whether the C backplane pin forwards the internal oscillator. This lets several units run from one time base. Setting the hold flag parks every unit in a dark halt state with its counter cleared. A later write with the flag clear releases it, and the unit then starts phase A+ on the next tick it counts. Units that share a tick therefore start together.

Top module: `lcd3_mux_seq`

States are `ST_HALT`, `ST_APOS`, `ST_ANEG`, `ST_BPOS`, `ST_BNEG`, `ST_CPOS` and `ST_CNEG`. The transitions are:
- start: `ST_HALT` to `ST_APOS` on a counted tick while not held.
- advance: a phase moves to its successor on the last tick of the phase.
- wrap: `ST_CNEG` returns to `ST_APOS`.
- stop: any state goes to `ST_HALT` on a control write with the hold flag set.

## Requirements
- R1: After reset the unit is in `ST_HALT` and not held, so every level output is 0. The role is stand-alone: `bpc_osc_out`=1, `bpa_osc_in`=0, and `osc_out` follows `int_tick`.
- R2: Counted ticks step the phases in the order A+, A−, B+, B−, C+, C−, then wrap to A+. Each phase lasts exactly 32 counted ticks. Leaving `ST_HALT` takes one counted tick and enters A+ at its first tick position. Level outputs change only in the cycle after a counted tick or a control write.
- R3: During a backplane's own positive phase its level is 3, and during its own negative phase it is 0. Every other backplane shows 1 during any positive phase and 2 during any negative phase. `bp_lvl[1:0]` is A, `[3:2]` is B and `[5:4]` is C.
- R4: In a positive phase a segment line shows 0 when its bit is on and 2 when it is off. In a negative phase it shows 3 when on and 1 when off.
- R5: Digit n (n=0..3) takes byte `seg_bits[8n+7:8n]`, where bit 7 is H and bit 0 is A. Its lines are SA = `seg_lvl[6n+1:6n]`, SB = `seg_lvl[6n+3:6n+2]` and SC = `seg_lvl[6n+5:6n+4]`. The bits map as follows:
  - Backplane A: SA takes B (bit 1), SB takes A (bit 0), SC takes F (bit 5).
  - Backplane B: SA takes C (bit 2), SB takes G (bit 6), SC takes E (bit 4).
  - Backplane C: SA takes H (bit 7), SB takes D (bit 3).
- R6: With backplane C selected, line SC of digit n shows `sp_bits[n]`.
- R7: A control write with `sync_in`=1 puts the unit in `ST_HALT` with its counter cleared from the next cycle on. All levels are then 0, and ticks have no effect while the unit is held.
- R8: A control write with `sync_in`=0 releases the hold. The next counted tick enters A+ at its first tick position.
- R9: A control write takes priority over a tick in the same cycle, and that tick is not counted.
- R10: `mode_in` is latched on a control write. Code 2'b11 selects slave: only `ext_tick` is counted, `bpa_osc_in`=1, `bpc_osc_out`=0 and `osc_out`=0. Codes 2'b00 (master), 2'b01 (stand-alone) and 2'b10 (treated as stand-alone) count only `int_tick`, with `bpa_osc_in`=0, `bpc_osc_out`=1 and `osc_out`=`int_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_tick | input | 1 | One-cycle pulse from the local oscillator |
| ext_tick | input | 1 | One-cycle pulse arriving on the A backplane pin in slave role |
| ctrl_wr | input | 1 | Control write strobe |
| mode_in | input | 2 | Role code latched on `ctrl_wr` |
| sync_in | input | 1 | Hold flag latched on `ctrl_wr` |
| seg_bits | input | 32 | Latched digit bytes, digit n in bits 8n+7..8n |
| sp_bits | input | 4 | Latched special-segment bits, one per digit |
| bp_lvl | output | 6 | Backplane level codes for A, B and C |
| seg_lvl | output | 24 | Segment line level codes, three lines per digit |
| bpa_osc_in | output | 1 | A backplane pin acts as oscillator input |
| bpc_osc_out | output | 1 | C backplane pin carries the oscillator |
| osc_out | output | 1 | Forwarded internal tick for cascaded units |

## Verification
The two functions that can coincide are a control write and the counting of a tick. They are provoked by raising `ctrl_wr` in the same cycle as a counted tick, both while running (with the hold clear) and with the hold set mid-phase. The run is judged by checking, on every clock against a behavioural model, that the phase position has not moved and that a hold write blanks every output on the next cycle. The same comparison also covers the release from halt on the first counted tick and the role switch to slave, where `int_tick` pulses must leave the sequence frozen.

// File: rtl/lcd3_pkg.sv
package lcd3_pkg;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_APOS,
        ST_ANEG,
        ST_BPOS,
        ST_BNEG,
        ST_CPOS,
        ST_CNEG
    } phase_e;

    localparam logic [1:0] MD_MASTER = 2'b00;
    localparam logic [1:0] MD_SOLO   = 2'b01;
    localparam logic [1:0] MD_SPARE  = 2'b10;
    localparam logic [1:0] MD_SLAVE  = 2'b11;

    localparam logic [1:0] LV_ZERO  = 2'd0;
    localparam logic [1:0] LV_THIRD = 2'd1;
    localparam logic [1:0] LV_TWO3  = 2'd2;
    localparam logic [1:0] LV_FULL  = 2'd3;

    function automatic phase_e phase_succ(input phase_e cur);
        phase_e r;
        unique case (cur)
            ST_APOS: r = ST_ANEG;
            ST_ANEG: r = ST_BPOS;
            ST_BPOS: r = ST_BNEG;
            ST_BNEG: r = ST_CPOS;
            ST_CPOS: r = ST_CNEG;
            default: r = ST_APOS;
        endcase
        return r;
    endfunction

    function automatic logic [1:0] seg_code(input logic run, input logic pos, input logic on);
        logic [1:0] r;
        if (!run)     r = LV_ZERO;
        else if (pos) r = on ? LV_ZERO : LV_TWO3;
        else          r = on ? LV_FULL : LV_THIRD;
        return r;
    endfunction

endpackage

// File: rtl/lcd3_phase_fsm.sv
module lcd3_phase_fsm
    import lcd3_pkg::*;
#(
    parameter int TICKS_PER_PHASE = 32
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   ctrl_wr,
    input  logic   sync_in,
    output phase_e state_o
);
    localparam int CW = (TICKS_PER_PHASE > 2) ? $clog2(TICKS_PER_PHASE) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_PHASE - 1);

    phase_e        state_q, state_d;
    logic [CW-1:0] pos_q, pos_d;
    logic          hold_q, hold_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            pos_q   <= '0;
            hold_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            hold_q  <= hold_d;
        end
    end

    // transitions: a control write pre-empts the tick of the same cycle
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        hold_d  = hold_q;
        if (ctrl_wr) begin
            hold_d = sync_in;
            if (sync_in) begin
                state_d = ST_HALT;
                pos_d   = '0;
            end
        end else if (tick) begin
            unique case (state_q)
                ST_HALT: begin
                    if (!hold_q) begin
                        state_d = ST_APOS;
                        pos_d   = '0;
                    end
                end
                default: begin
                    if (pos_q == LAST) begin
                        pos_d   = '0;
                        state_d = phase_succ(state_q);
                    end else begin
                        pos_d = pos_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/lcd3_level_map.sv
module lcd3_level_map
    import lcd3_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input  phase_e                    state,
    input  logic [8*NUM_DIGITS-1:0]   seg_bits,
    input  logic [NUM_DIGITS-1:0]     sp_bits,
    output logic [5:0]                bp_lvl,
    output logic [6*NUM_DIGITS-1:0]   seg_lvl
);
    logic       run, pos;
    logic [2:0] sel;

    // output decode of the phase state
    always_comb begin
        run = 1'b1;
        pos = 1'b0;
        sel = 3'b000;
        unique case (state)
            ST_HALT: run = 1'b0;
            ST_APOS: begin pos = 1'b1; sel = 3'b001; end
            ST_ANEG: sel = 3'b001;
            ST_BPOS: begin pos = 1'b1; sel = 3'b010; end
            ST_BNEG: sel = 3'b010;
            ST_CPOS: begin pos = 1'b1; sel = 3'b100; end
            ST_CNEG: sel = 3'b100;
            default: run = 1'b0;
        endcase
    end

    for (genvar b = 0; b < 3; b++) begin : g_bp
        assign bp_lvl[2*b +: 2] = !run   ? LV_ZERO :
                                  sel[b] ? (pos ? LV_FULL : LV_ZERO) :
                                           (pos ? LV_THIRD : LV_TWO3);
    end

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
        logic [7:0] byt;
        logic       on_sa, on_sb, on_sc;
        assign byt   = seg_bits[8*d +: 8];
        assign on_sa = sel[0] ? byt[1] : sel[1] ? byt[2] : byt[7];
        assign on_sb = sel[0] ? byt[0] : sel[1] ? byt[6] : byt[3];
        assign on_sc = sel[0] ? byt[5] : sel[1] ? byt[4] : sp_bits[d];
        assign seg_lvl[6*d +: 2]     = seg_code(run, pos, on_sa);
        assign seg_lvl[6*d + 2 +: 2] = seg_code(run, pos, on_sb);
        assign seg_lvl[6*d + 4 +: 2] = seg_code(run, pos, on_sc);
    end

endmodule

// File: rtl/lcd3_mux_seq.sv
module lcd3_mux_seq
    import lcd3_pkg::*;
#(
    parameter int NUM_DIGITS      = 4,
    parameter int TICKS_PER_PHASE = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      int_tick,
    input  logic                      ext_tick,
    input  logic                      ctrl_wr,
    input  logic [1:0]                mode_in,
    input  logic                      sync_in,
    input  logic [8*NUM_DIGITS-1:0]   seg_bits,
    input  logic [NUM_DIGITS-1:0]     sp_bits,
    output logic [5:0]                bp_lvl,
    output logic [6*NUM_DIGITS-1:0]   seg_lvl,
    output logic                      bpa_osc_in,
    output logic                      bpc_osc_out,
    output logic                      osc_out
);
    logic [1:0] mode_q;
    logic       is_slave;
    logic       adv_tick;
    logic       running;
    phase_e     state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= MD_SOLO;
        else if (ctrl_wr) mode_q <= mode_in;
    end

    assign is_slave    = (mode_q == MD_SLAVE);
    assign adv_tick    = is_slave ? ext_tick : int_tick;
    assign bpa_osc_in  = is_slave;
    assign bpc_osc_out = !is_slave;
    assign osc_out     = !is_slave && int_tick;
    assign running     = (state != ST_HALT);

    lcd3_phase_fsm #(.TICKS_PER_PHASE(TICKS_PER_PHASE)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (adv_tick),
        .ctrl_wr (ctrl_wr),
        .sync_in (sync_in),
        .state_o (state)
    );

    lcd3_level_map #(.NUM_DIGITS(NUM_DIGITS)) u_map (
        .state    (state),
        .seg_bits (seg_bits),
        .sp_bits  (sp_bits),
        .bp_lvl   (bp_lvl),
        .seg_lvl  (seg_lvl)
    );

endmodule

// File: rtl/lcd3_mux_seq_chk.sv
module lcd3_mux_seq_chk #(
    parameter int NUM_DIGITS = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ctrl_wr,
    input logic                    sync_in,
    input logic                    adv_tick,
    input logic                    running,
    input logic [5:0]              bp_lvl,
    input logic [6*NUM_DIGITS-1:0] seg_lvl,
    input logic                    bpa_osc_in,
    input logic                    bpc_osc_out,
    input logic                    osc_out
);
    localparam int NL = 3 * NUM_DIGITS;

    logic [2:0]    extreme;
    logic [2:0]    at_full;
    logic [NL-1:0] seg_lo;

    for (genvar b = 0; b < 3; b++) begin : g_b
        assign extreme[b] = (bp_lvl[2*b +: 2] == 2'd0) || (bp_lvl[2*b +: 2] == 2'd3);
        assign at_full[b] = (bp_lvl[2*b +: 2] == 2'd3);
    end
    for (genvar k = 0; k < NL; k++) begin : g_s
        assign seg_lo[k] = seg_lvl[2*k];
    end

    // R7: a hold write blanks the unit on the next cycle
    a_r7_hold_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && sync_in |=> !running && (bp_lvl == '0) && (seg_lvl == '0));

    // R3: exactly one backplane at an extreme level while running
    a_r3_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> ($countones(extreme) == 1));

    // R4: segment codes are even in positive phases, odd in negative ones
    a_r4_seg_pos: assert property (@(posedge clk) disable iff (!rst_n)
        running && (at_full != 3'b000) |-> (seg_lo == '0));
    a_r4_seg_neg: assert property (@(posedge clk) disable iff (!rst_n)
        running && (at_full == 3'b000) |-> (&seg_lo));

    // R10: pin roles are exclusive and the forwarded tick needs the C pin role
    a_r10_roles: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({bpa_osc_in, bpc_osc_out}) == 1) && (!osc_out || bpc_osc_out));

    // R2: without a counted tick or control write the backplanes stand still
    a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_tick && !ctrl_wr |=> $stable(bp_lvl) && $stable(running));

    // R9: a release write swallows a coincident tick
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !sync_in && running |=> $stable(bp_lvl) && running);

endmodule

bind lcd3_mux_seq lcd3_mux_seq_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (ctrl_wr),
    .sync_in     (sync_in),
    .adv_tick    (adv_tick),
    .running     (running),
    .bp_lvl      (bp_lvl),
    .seg_lvl     (seg_lvl),
    .bpa_osc_in  (bpa_osc_in),
    .bpc_osc_out (bpc_osc_out),
    .osc_out     (osc_out)
);

// File: tb/lcd3_mux_seq_test.sv
module lcd3_mux_seq_test;
    localparam int ND = 4;
    localparam int TPP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          int_tick = 1'b0, ext_tick = 1'b0, ctrl_wr = 1'b0, sync_in = 1'b0;
    logic [1:0]    mode_in = 2'b01;
    logic [8*ND-1:0] seg_bits = '0;
    logic [ND-1:0] sp_bits = '0;
    logic [5:0]    bp_lvl;
    logic [6*ND-1:0] seg_lvl;
    logic          bpa_osc_in, bpc_osc_out, osc_out;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    // behavioural reference state: ph 0 = halted, 1..6 = A+,A-,B+,B-,C+,C-
    int ph = 0, cnt = 0;
    bit held = 0;
    logic [1:0] md = 2'b01;

    always #10 clk = ~clk;

    lcd3_mux_seq #(.NUM_DIGITS(ND), .TICKS_PER_PHASE(TPP)) uut (
        .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_tick(ext_tick),
        .ctrl_wr(ctrl_wr), .mode_in(mode_in), .sync_in(sync_in),
        .seg_bits(seg_bits), .sp_bits(sp_bits), .bp_lvl(bp_lvl), .seg_lvl(seg_lvl),
        .bpa_osc_in(bpa_osc_in), .bpc_osc_out(bpc_osc_out), .osc_out(osc_out));

    always @(posedge clk) begin
        bit t;
        if (!rst_n) begin
            ph = 0; cnt = 0; held = 0; md = 2'b01;
        end else begin
            t = (md == 2'b11) ? ext_tick : int_tick;
            if (ctrl_wr) begin
                md = mode_in; held = sync_in;
                if (sync_in) begin ph = 0; cnt = 0; end
            end else if (t) begin
                if (ph == 0) begin
                    if (!held) begin ph = 1; cnt = 0; end
                end else begin
                    cnt++;
                    if (cnt == TPP) begin cnt = 0; ph = (ph == 6) ? 1 : ph + 1; end
                end
            end
        end
    end

    function automatic bit bit_on(int line_kind, int bp, int dig);
        logic [7:0] by = seg_bits[8*dig +: 8];
        case ({line_kind[1:0], bp[1:0]})
            4'b0000: return by[1];
            4'b0001: return by[2];
            4'b0010: return by[7];
            4'b0100: return by[0];
            4'b0101: return by[6];
            4'b0110: return by[3];
            4'b1000: return by[5];
            4'b1001: return by[4];
            default: return sp_bits[dig];
        endcase
    endfunction

    task automatic check_all();
        logic [5:0] eb = '0;
        logic [6*ND-1:0] es = '0;
        logic [2:0] er;
        int act = (ph - 1) / 2;
        bit pos = (ph % 2) == 1;
        if (ph != 0) begin
            for (int b = 0; b < 3; b++)
                eb[2*b +: 2] = (b == act) ? (pos ? 2'd3 : 2'd0) : (pos ? 2'd1 : 2'd2);
            for (int k = 0; k < 3*ND; k++) begin
                bit on = bit_on(k % 3, act, k / 3);
                es[2*k +: 2] = pos ? (on ? 2'd0 : 2'd2) : (on ? 2'd3 : 2'd1);
            end
        end
        er = (md == 2'b11) ? 3'b100 : {1'b0, 1'b1, int_tick};
        n_cmp++;
        if (bp_lvl !== eb) begin
            n_bad++;
            $display("FAIL %s bp_lvl actual=%h expected=%h t=%0t", cur_req, bp_lvl, eb, $time);
        end
        n_cmp++;
        if (seg_lvl !== es) begin
            n_bad++;
            $display("FAIL %s seg_lvl actual=%h expected=%h t=%0t", cur_req, seg_lvl, es, $time);
        end
        n_cmp++;
        if ({bpa_osc_in, bpc_osc_out, osc_out} !== er) begin
            n_bad++;
            $display("FAIL %s roles actual=%b expected=%b t=%0t", cur_req,
                     {bpa_osc_in, bpc_osc_out, osc_out}, er, $time);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic wr(logic [1:0] m, logic s);
        mode_in = m; sync_in = s; ctrl_wr = 1'b1;
        step(1);
        ctrl_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired (req %s) actual=hung expected=finished", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, dark halt, stand-alone roles
        cur_req = "R1";
        step(3);
        rst_n = 1'b1;
        step(3);

        // R2: start on first tick, phase order and length over more than a frame
        cur_req = "R2";
        seg_bits = 32'hA5C3_3C5A; sp_bits = 4'b1010;
        int_tick = 1'b1;
        step(200);
        int_tick = 1'b0;
        for (int i = 0; i < 260; i++) begin
            int_tick = (i % 3 == 0);
            step(1);
        end
        int_tick = 1'b0;

        // R5: walking single bit across every digit byte
        cur_req = "R5";
        sp_bits = '0;
        int_tick = 1'b1;
        for (int i = 0; i < 8*ND; i++) begin
            seg_bits = 32'd1 << i;
            step(6*TPP);
        end

        // R6: special bits on the C lines
        cur_req = "R6";
        seg_bits = '0;
        for (int i = 0; i < ND; i++) begin
            sp_bits = 4'd1 << i;
            step(6*TPP);
        end

        // R3 / R4: data changing mid-phase under irregular ticks
        cur_req = "R4";
        for (int i = 0; i < 600; i++) begin
            int_tick = ($urandom % 2) == 1;
            if (i % 37 == 0) begin seg_bits = $urandom; sp_bits = 4'($urandom); end
            step(1);
        end
        cur_req = "R3";
        int_tick = 1'b1;
        step(6*TPP);

        // R7: hold write mid-frame, ticks ignored while held
        cur_req = "R7";
        step(45);
        wr(2'b01, 1'b1);
        step(80);

        // R8: release, then first tick enters A+
        cur_req = "R8";
        int_tick = 1'b0;
        wr(2'b01, 1'b0);
        step(4);
        int_tick = 1'b1;
        step(70);

        // R9: control writes coinciding with counted ticks
        cur_req = "R9";
        for (int i = 0; i < 5; i++) begin
            wr(2'b01, 1'b0);
            step(7);
        end
        wr(2'b00, 1'b1);
        step(3);
        wr(2'b00, 1'b0);
        step(40);

        // R10: slave counts only ext_tick; spare code behaves as stand-alone
        cur_req = "R10";
        wr(2'b11, 1'b0);
        for (int i = 0; i < 60; i++) begin
            int_tick = (i % 2 == 0); ext_tick = 1'b0;
            step(1);
        end
        for (int i = 0; i < 400; i++) begin
            int_tick = (i % 2 == 0); ext_tick = (i % 3 == 0);
            step(1);
        end
        ext_tick = 1'b0;
        wr(2'b10, 1'b0);
        for (int i = 0; i < 120; i++) begin
            int_tick = (i % 2 == 1); ext_tick = 1'b1;
            step(1);
        end
        wr(2'b00, 1'b0);
        step(50);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule